// File: doc/BRIEF.md
# Test Access Port State Controller

This block is the sequencing core of a boundary-scan test port. It is a sixteen-state machine clocked by the test clock `tck`. The single mode-select input `tms` steers it on each rising edge. From the idle state the machine enters one of two branches. One branch handles data-register scans and the other handles instruction-register scans. Both branches have the same seven-step structure: select, capture, shift, first exit, pause, second exit, update.

The controller holds no scan data and decodes no instruction. It drives a set of control strobes that the surrounding scan registers obey:

- a capture strobe, a shift strobe and an update strobe for each branch;
- a reset strobe that is high in the reset state;
- an idle indication;
- an output-enable for the serial data pin.

The output-enable is registered on the falling edge of `tck`, so a serial output stage that also updates on that edge sees it in step. It is high only in the two shift states. It therefore drops while a scan is paused.

An active-low reset pin returns the machine to the reset state. With `ASYNC_RST=1`, the default, this happens at once and does not wait for a clock edge. With `ASYNC_RST=0` the pin acts at the next rising edge. Holding `tms` high for five edges also reaches the reset state from anywhere, so the pin is optional in a system. All pins are plain control signals; the block has no streaming interface.

Top module: `tap_ctrl`

## Requirements
- R1: `state_o` reports the current state with this encoding:
  - 0 = reset, 1 = idle;
  - data branch: 2 = select, 3 = capture, 4 = shift, 5 = exit-1, 6 = pause, 7 = exit-2, 8 = update;
  - instruction branch: 9 = select, 10 = capture, 11 = shift, 12 = exit-1, 13 = pause, 14 = exit-2, 15 = update.
- R2: In reset, `tms`=1 holds and `tms`=0 moves to idle. In idle, `tms`=0 holds and `tms`=1 moves to data-select. All state changes happen on the rising edge of `tck`.
- R3: In either branch, select goes to capture on `tms`=0 and capture goes to shift on `tms`=0. Capture goes to exit-1 on `tms`=1, and shift holds on 0 and goes to exit-1 on 1. Data-select with `tms`=1 goes to instruction-select, and instruction-select with `tms`=1 goes to reset.
- R4: In either branch, exit-1 goes to pause on 0 and to update on 1. Pause holds on 0 and goes to exit-2 on 1. Exit-2 goes back to shift on 0 and to update on 1.
- R5: Both update states go to idle on `tms`=0 and to data-select on `tms`=1.
- R6: Five consecutive rising edges with `tms`=1 reach the reset state from every one of the sixteen states.
- R7: `rst_o` is high exactly in reset and `idle_o` exactly in idle. Each capture, shift and update strobe is high exactly while the machine is in its matching state. At most one of these eight outputs is high at any time.
- R8: `tdo_en_o` is updated on the falling edge of `tck`. It is high only after a falling edge at which the state was data-shift or instruction-shift, and it is low in every pause state.
- R9: With `ASYNC_RST=1`, `trst_n`=0 forces the reset state at once, with no clock edge. `tdo_en_o` clears at the same moment and `rst_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset to the reset state |
| tms | input | 1 | Mode select, sampled on the rising edge |
| state_o | output | 4 | Current state code (R1) |
| rst_o | output | 1 | High in the reset state |
| idle_o | output | 1 | High in the idle state |
| cap_dr_o | output | 1 | Data-branch capture strobe |
| shf_dr_o | output | 1 | Data-branch shift strobe |
| upd_dr_o | output | 1 | Data-branch update strobe |
| cap_ir_o | output | 1 | Instruction-branch capture strobe |
| shf_ir_o | output | 1 | Instruction-branch shift strobe |
| upd_ir_o | output | 1 | Instruction-branch update strobe |
| tdo_en_o | output | 1 | Serial output enable, falling-edge registered |

## Verification
The `tms` value present at a rising edge sets `state_o` and all strobes just after that same edge, with no further delay. `tdo_en_o` follows half a period later, at the falling edge. The bench changes `tms` one nanosecond before a rising edge and samples every output one nanosecond before the next rising edge. Each sample therefore sees exactly one transition, and the enable has had its falling edge to settle. The asynchronous reset is checked between edges, in the same cycle that `trst_n` is pulled low.

// File: rtl/tap_ctrl_pkg.sv
`timescale 1ns/1ps
package tap_ctrl_pkg;
  localparam int ST_W       = 4;
  localparam int BRANCH_LEN = 7;
  localparam int DR_BASE    = 2;
  localparam int IR_BASE    = DR_BASE + BRANCH_LEN;

  localparam logic [ST_W-1:0] ST_RESET  = 4'd0;
  localparam logic [ST_W-1:0] ST_IDLE   = 4'd1;
  localparam logic [ST_W-1:0] ST_SEL_DR = ST_W'(DR_BASE);
  localparam logic [ST_W-1:0] ST_SEL_IR = ST_W'(IR_BASE);

  // step offsets inside a branch; the order is part of the state code
  localparam logic [ST_W-1:0] OFS_SEL = 4'd0;
  localparam logic [ST_W-1:0] OFS_CAP = 4'd1;
  localparam logic [ST_W-1:0] OFS_SHF = 4'd2;
  localparam logic [ST_W-1:0] OFS_EX1 = 4'd3;
  localparam logic [ST_W-1:0] OFS_PAU = 4'd4;
  localparam logic [ST_W-1:0] OFS_EX2 = 4'd5;
  localparam logic [ST_W-1:0] OFS_UPD = 4'd6;
endpackage

// File: rtl/tap_branch_next.sv
`timescale 1ns/1ps
module tap_branch_next
  import tap_ctrl_pkg::*;
#(
  parameter int                BASE   = DR_BASE,
  parameter logic [ST_W-1:0]   ESCAPE = ST_SEL_IR
) (
  input  logic [ST_W-1:0] state,
  input  logic            tms,
  output logic            hit,
  output logic [ST_W-1:0] nxt
);
  localparam logic [ST_W-1:0] B = ST_W'(BASE);

  logic [ST_W-1:0] ofs;

  assign ofs = state - B;
  assign hit = (ofs < ST_W'(BRANCH_LEN));

  always_comb begin
    nxt = state;
    unique case (ofs)
      OFS_SEL: nxt = tms ? ESCAPE      : B + OFS_CAP;
      OFS_CAP: nxt = tms ? B + OFS_EX1 : B + OFS_SHF;
      OFS_SHF: nxt = tms ? B + OFS_EX1 : B + OFS_SHF;
      OFS_EX1: nxt = tms ? B + OFS_UPD : B + OFS_PAU;
      OFS_PAU: nxt = tms ? B + OFS_EX2 : B + OFS_PAU;
      OFS_EX2: nxt = tms ? B + OFS_UPD : B + OFS_SHF;
      OFS_UPD: nxt = tms ? ST_SEL_DR   : ST_IDLE;
      default: nxt = state;
    endcase
  end
endmodule

// File: rtl/tap_next.sv
`timescale 1ns/1ps
module tap_next
  import tap_ctrl_pkg::*;
(
  input  logic [ST_W-1:0] state,
  input  logic            tms,
  output logic [ST_W-1:0] nxt
);
  logic [1:0]      br_hit;
  logic [ST_W-1:0] br_nxt [2];

  for (genvar b = 0; b < 2; b++) begin : g_branch
    tap_branch_next #(
      .BASE   (b == 0 ? DR_BASE : IR_BASE),
      .ESCAPE (b == 0 ? ST_SEL_IR : ST_RESET)
    ) u_branch (
      .state (state),
      .tms   (tms),
      .hit   (br_hit[b]),
      .nxt   (br_nxt[b])
    );
  end

  always_comb begin
    if (state == ST_RESET)     nxt = tms ? ST_RESET  : ST_IDLE;
    else if (state == ST_IDLE) nxt = tms ? ST_SEL_DR : ST_IDLE;
    else if (br_hit[0])        nxt = br_nxt[0];
    else                       nxt = br_nxt[1];
  end
endmodule

// File: rtl/tap_state_reg.sv
`timescale 1ns/1ps
module tap_state_reg
  import tap_ctrl_pkg::*;
#(
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic [ST_W-1:0] nxt,
  output logic [ST_W-1:0] state
);
  if (ASYNC_RST) begin : g_async
    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= nxt;
    end
  end else begin : g_sync
    always_ff @(posedge tck) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= nxt;
    end
  end

  // run of consecutive TMS-high edges, saturating at five
  logic [2:0] ones_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              ones_run <= 3'd0;
    else if (!tms)            ones_run <= 3'd0;
    else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
  end

  a_r6_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_run == 3'd5) |-> (state == ST_RESET));

  a_r2_reset_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET && tms) |=> (state == ST_RESET));

  a_r2_idle_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_IDLE && !tms) |=> (state == ST_IDLE));
endmodule

// File: rtl/tap_strobes.sv
`timescale 1ns/1ps
module tap_strobes
  import tap_ctrl_pkg::*;
#(
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic [ST_W-1:0] state,
  output logic            rst_o,
  output logic            idle_o,
  output logic [1:0]      cap_o,
  output logic [1:0]      shf_o,
  output logic [1:0]      upd_o,
  output logic            tdo_en_o
);
  assign rst_o  = (state == ST_RESET);
  assign idle_o = (state == ST_IDLE);

  for (genvar b = 0; b < 2; b++) begin : g_br
    localparam logic [ST_W-1:0] B = ST_W'(b == 0 ? DR_BASE : IR_BASE);
    assign cap_o[b] = (state == B + OFS_CAP);
    assign shf_o[b] = (state == B + OFS_SHF);
    assign upd_o[b] = (state == B + OFS_UPD);
  end

  logic in_shift;
  assign in_shift = |shf_o;

  if (ASYNC_RST) begin : g_async
    always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) tdo_en_o <= 1'b0;
      else         tdo_en_o <= in_shift;
    end
  end else begin : g_sync
    always_ff @(negedge tck) begin
      if (!trst_n) tdo_en_o <= 1'b0;
      else         tdo_en_o <= in_shift;
    end
  end

  a_r8_enable_tracks_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en_o == (state == ST_W'(DR_BASE) + OFS_SHF || state == ST_W'(IR_BASE) + OFS_SHF));

  a_r8_off_in_pause: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_W'(DR_BASE) + OFS_PAU || state == ST_W'(IR_BASE) + OFS_PAU) |-> !tdo_en_o);

  a_r7_single_strobe: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({rst_o, idle_o, cap_o, shf_o, upd_o}));
endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
  import tap_ctrl_pkg::*;
#(
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output logic [3:0] state_o,
  output logic       rst_o,
  output logic       idle_o,
  output logic       cap_dr_o,
  output logic       shf_dr_o,
  output logic       upd_dr_o,
  output logic       cap_ir_o,
  output logic       shf_ir_o,
  output logic       upd_ir_o,
  output logic       tdo_en_o
);
  logic [ST_W-1:0] state;
  logic [ST_W-1:0] nxt;
  logic [1:0]      cap, shf, upd;

  tap_next u_next (
    .state (state),
    .tms   (tms),
    .nxt   (nxt)
  );

  tap_state_reg #(.ASYNC_RST(ASYNC_RST)) u_reg (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .nxt    (nxt),
    .state  (state)
  );

  tap_strobes #(.ASYNC_RST(ASYNC_RST)) u_strb (
    .tck      (tck),
    .trst_n   (trst_n),
    .state    (state),
    .rst_o    (rst_o),
    .idle_o   (idle_o),
    .cap_o    (cap),
    .shf_o    (shf),
    .upd_o    (upd),
    .tdo_en_o (tdo_en_o)
  );

  assign state_o  = state;
  assign cap_dr_o = cap[0];
  assign shf_dr_o = shf[0];
  assign upd_dr_o = upd[0];
  assign cap_ir_o = cap[1];
  assign shf_ir_o = shf[1];
  assign upd_ir_o = upd[1];

  a_r3_select_to_capture: assert property (@(posedge tck) disable iff (!trst_n)
    (state_o == ST_SEL_DR && !tms) |=> cap_dr_o);

  a_r3_ir_select_escape: assert property (@(posedge tck) disable iff (!trst_n)
    (state_o == ST_SEL_IR && tms) |=> rst_o);

  a_r5_update_to_idle: assert property (@(posedge tck) disable iff (!trst_n)
    ((upd_dr_o || upd_ir_o) && !tms) |=> idle_o);

  a_r4_pause_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (state_o == 4'd6 && !tms) |=> (state_o == 4'd6));
endmodule

// File: tb/tap_ctrl_tb.sv
`timescale 1ns/1ps
module tap_ctrl_tb;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic [3:0] state_o;
  logic       rst_o, idle_o, cap_dr_o, shf_dr_o, upd_dr_o;
  logic       cap_ir_o, shf_ir_o, upd_ir_o, tdo_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0]  exp_st = 4'd0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 tck = ~tck;

  tap_ctrl u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state_o),
    .rst_o(rst_o), .idle_o(idle_o), .cap_dr_o(cap_dr_o), .shf_dr_o(shf_dr_o),
    .upd_dr_o(upd_dr_o), .cap_ir_o(cap_ir_o), .shf_ir_o(shf_ir_o),
    .upd_ir_o(upd_ir_o), .tdo_en_o(tdo_en_o)
  );

  // expected next state, written from the transition requirements
  function automatic logic [3:0] model_next(logic [3:0] s, logic t);
    case (s)
      4'd0:  return t ? 4'd0 : 4'd1;
      4'd1:  return t ? 4'd2 : 4'd1;
      4'd2:  return t ? 4'd9 : 4'd3;
      4'd9:  return t ? 4'd0 : 4'd10;
      4'd8, 4'd15: return t ? 4'd2 : 4'd1;
      default: begin
        logic [3:0] b;
        logic [3:0] o;
        b = (s < 4'd9) ? 4'd2 : 4'd9;
        o = s - b;
        case (o)
          4'd1:    return t ? b + 4'd3 : b + 4'd2;
          4'd2:    return t ? b + 4'd3 : b + 4'd2;
          4'd3:    return t ? b + 4'd6 : b + 4'd4;
          4'd4:    return t ? b + 4'd5 : b + 4'd4;
          default: return t ? b + 4'd6 : b + 4'd2;
        endcase
      end
    endcase
  endfunction

  function automatic string trans_tag(logic [3:0] s);
    if (s <= 4'd1) return "R2";
    if (s == 4'd8 || s == 4'd15) return "R5";
    if ((s >= 4'd5 && s <= 4'd7) || (s >= 4'd12 && s <= 4'd14)) return "R4";
    return "R3";
  endfunction

  task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs(string tag);
    check1(tag, {28'd0, state_o}, {28'd0, exp_st});
    check1("R7", {23'd0, rst_o, idle_o, cap_dr_o, shf_dr_o, upd_dr_o,
                  cap_ir_o, shf_ir_o, upd_ir_o, 1'b0},
           {23'd0, exp_st == 4'd0, exp_st == 4'd1, exp_st == 4'd3, exp_st == 4'd4,
            exp_st == 4'd8, exp_st == 4'd10, exp_st == 4'd11, exp_st == 4'd15, 1'b0});
    check1("R8", {31'd0, tdo_en_o}, {31'd0, exp_st == 4'd4 || exp_st == 4'd11});
  endtask

  // called at sample time (1 ns before a rising edge)
  task automatic step(logic v, string tag_override);
    logic [3:0] prev;
    prev = exp_st;
    tms = v;
    @(posedge tck);
    exp_st = model_next(exp_st, v);
    #9;
    check_outputs(tag_override.len() != 0 ? tag_override : trans_tag(prev));
  endtask

  task automatic walk_to(logic [3:0] target);
    for (int n = 0; n < 400 && exp_st != target; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], "");
    end
    check1("R1", {28'd0, state_o}, {28'd0, target});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #23;
    // R9 and R7: reset state while the pin is low
    check1("R9", {28'd0, state_o}, 32'd0);
    check1("R9", {31'd0, tdo_en_o}, 32'd0);
    check1("R7", {31'd0, rst_o}, 32'd1);
    @(posedge tck);
    trst_n = 1'b1;
    #8;
    exp_st = 4'd0;

    // R2-R5: every state, both TMS values
    for (int s = 0; s < 16; s++) begin
      for (int v = 0; v < 2; v++) begin
        walk_to(4'(s));
        step(v[0], "");
      end
    end

    // R6: five high TMS edges from every state
    for (int s = 0; s < 16; s++) begin
      walk_to(4'(s));
      for (int k = 0; k < 5; k++) step(1'b1, "R6");
      check1("R6", {28'd0, state_o}, 32'd0);
    end

    // R8: enable follows shift and drops in pause (data branch walk)
    walk_to(4'd4);
    step(1'b0, "R8");
    step(1'b1, "R8");
    step(1'b0, "R8");
    check1("R8", {31'd0, tdo_en_o}, 32'd0);
    step(1'b1, "R8");
    step(1'b0, "R8");
    check1("R8", {31'd0, tdo_en_o}, 32'd1);

    // R9: asynchronous reset between edges from instruction shift
    walk_to(4'd11);
    tms = 1'b0;
    @(posedge tck);
    #1;
    trst_n = 1'b0;
    #1;
    check1("R9", {28'd0, state_o}, 32'd0);
    check1("R9", {31'd0, tdo_en_o}, 32'd0);
    check1("R9", {31'd0, rst_o}, 32'd1);
    #6;
    trst_n = 1'b1;
    exp_st = 4'd0;
    #1;
    step(1'b0, "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule